// File: doc/BRIEF.md
# Three-State Single-Segment Two-Digit Display Scanner

This block shows a two-digit seconds count, from 00 to 99, on two seven-segment digits. Both digits hang on the same seven bidirectional lines, and there are no digit-select transistors. The tens digit is common-cathode and the units digit is common-anode. The block turns on only one segment of one digit at any moment. It does this by enabling a single line and leaving every other line at high impedance. The level on the enabled line picks the digit: high lights the common-cathode tens digit and low lights the common-anode units digit.

A frame is 14 slots. The first seven slots walk lines 0 to 6 at the tens polarity, and the next seven walk lines 0 to 6 again at the units polarity. A prescaler divides the system clock into slots, nominally 1 ms each. A second divider counts slots into seconds and advances a BCD counter that wraps from 99 to 00. The digit values are captured once per frame, at its first slot, so the value shown never changes partway through a scan. At the start of every slot there is a short window with all lines released, so the previous line is off before the next one turns on.

The block is meant to sit beside pad cells that turn each data/enable pair into a three-state pin.

Top module: `seg_scan_top`

## Requirements
- R1: No more than one bit of `line_oe` is ever set.
- R2: When a line is enabled during a tens slot, its `line_out` bit is 1. When a line is enabled during a units slot, its `line_out` bit is 0.
- R3: Each slot lasts CLK_PER_SLOT clock cycles. Frame slot k (k = 0..13) drives line k mod 7, at the tens polarity for k < 7 and at the units polarity for k ≥ 7. Line i carries segment i, with a=0, b=1, c=2, d=3, e=4, f=5, g=6.
- R4: During the first GAP_CYCLES cycles of every slot, `line_oe` is all zero.
- R5: If the slot's segment is off in the digit pattern, `line_oe` stays all zero for the whole slot.
- R6: A segment is on when its bit is 1 in the digit pattern, with bit i standing for line i. The patterns are: 0=0x3F, 1=0x06, 2=0x5B, 3=0x4F, 4=0x66, 5=0x6D, 6=0x7D, 7=0x07, 8=0x7F, 9=0x6F.
- R7: The seconds count goes up by one every SLOTS_PER_SEC slots, and each of its BCD digits stays within 0..9. After 99 the count goes to 00.
- R8: The digits shown in frame f are the count as it stood just before the frame's first slot began. Counting from reset, that value is 0 for f = 0 and floor((14f−1)/SLOTS_PER_SEC) mod 100 for f ≥ 1. The digits stay unchanged through the frame.
- R9: A synchronous reset sets the count to 00, the scan position to tens line 0 and the slot phase to 0. On the cycle after reset, `line_oe` is all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| line_out | output | 7 | Per-line drive level (1 = tens polarity, 0 = units polarity) |
| line_oe | output | 7 | Per-line output enable; a clear bit means high impedance |

## Verification
Reaching the hard cases from the ports takes a long time at the nominal rates. The count has to get past 99, and a seconds tick has to arrive in the middle of a frame so that the frame capture actually matters. The bench therefore builds the block with an eight-cycle slot and a twenty-slot second. Twenty is not a multiple of the 14-slot frame, so ticks fall at varying points inside frames. The count wraps after about 143 frames. The bench visits selected frames up to and past the wrap, including a reset issued in the middle of a run, and checks every cycle of those frames against a timing model built from elapsed cycles.

// File: rtl/seg_scan_pkg.sv
package seg_scan_pkg;

    localparam int NUM_LINES       = 7;
    localparam int SLOTS_PER_FRAME = 2 * NUM_LINES;

    typedef enum logic {
        DIG_TENS  = 1'b0,
        DIG_UNITS = 1'b1
    } digit_sel_e;

    typedef logic [2:0]           line_idx_t;
    typedef logic [NUM_LINES-1:0] seg_pat_t;

    typedef struct packed {
        digit_sel_e digit;
        line_idx_t  line;
    } scan_pos_t;

    typedef struct packed {
        logic [3:0] tens;
        logic [3:0] units;
    } bcd_pair_t;

    localparam line_idx_t LAST_LINE = line_idx_t'(NUM_LINES - 1);

    function automatic seg_pat_t seg_decode(input logic [3:0] v);
        seg_pat_t p;
        case (v)
            4'd0:    p = 7'h3F;
            4'd1:    p = 7'h06;
            4'd2:    p = 7'h5B;
            4'd3:    p = 7'h4F;
            4'd4:    p = 7'h66;
            4'd5:    p = 7'h6D;
            4'd6:    p = 7'h7D;
            4'd7:    p = 7'h07;
            4'd8:    p = 7'h7F;
            4'd9:    p = 7'h6F;
            default: p = 7'h00;
        endcase
        return p;
    endfunction

    function automatic scan_pos_t next_pos(input scan_pos_t p);
        scan_pos_t n;
        if (p.line == LAST_LINE) begin
            n.line  = '0;
            n.digit = (p.digit == DIG_TENS) ? DIG_UNITS : DIG_TENS;
        end else begin
            n.line  = p.line + 3'd1;
            n.digit = p.digit;
        end
        return n;
    endfunction

    function automatic bcd_pair_t bcd_inc(input bcd_pair_t c);
        bcd_pair_t n;
        if (c.units == 4'd9) begin
            n.units = 4'd0;
            n.tens  = (c.tens == 4'd9) ? 4'd0 : c.tens + 4'd1;
        end else begin
            n.units = c.units + 4'd1;
            n.tens  = c.tens;
        end
        return n;
    endfunction

endpackage

// File: rtl/scan_prescaler.sv
module scan_prescaler #(
    parameter  int CLK_PER_SLOT = 125000,
    localparam int PHASE_W      = $clog2(CLK_PER_SLOT)
) (
    input  logic               clk,
    input  logic               rst,
    output logic               slot_end,
    output logic [PHASE_W-1:0] phase
);

    localparam logic [PHASE_W-1:0] PHASE_MAX = PHASE_W'(CLK_PER_SLOT - 1);

    assign slot_end = (phase == PHASE_MAX);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= '0;
        end else if (slot_end) begin
            phase <= '0;
        end else begin
            phase <= phase + 1'b1;
        end
    end

endmodule

// File: rtl/sec_counter.sv
module sec_counter
    import seg_scan_pkg::*;
#(
    parameter  int SLOTS_PER_SEC = 1000,
    localparam int SC_W          = $clog2(SLOTS_PER_SEC)
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      slot_tick,
    output bcd_pair_t count
);

    localparam logic [SC_W-1:0] SC_MAX = SC_W'(SLOTS_PER_SEC - 1);

    logic [SC_W-1:0] slot_cnt;
    logic            sec_tick;

    assign sec_tick = slot_tick && (slot_cnt == SC_MAX);

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_cnt <= '0;
        end else if (slot_tick) begin
            slot_cnt <= (slot_cnt == SC_MAX) ? '0 : slot_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (sec_tick) begin
            count <= bcd_inc(count);
        end
    end

endmodule

// File: rtl/scan_sequencer.sv
module scan_sequencer
    import seg_scan_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      slot_end,
    input  bcd_pair_t count,
    output scan_pos_t pos,
    output bcd_pair_t latched,
    output logic      frame_start
);

    assign frame_start = slot_end && (pos.digit == DIG_UNITS) && (pos.line == LAST_LINE);

    always_ff @(posedge clk) begin
        if (rst) begin
            pos <= '{digit: DIG_TENS, line: '0};
        end else if (slot_end) begin
            pos <= next_pos(pos);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            latched <= '0;
        end else if (frame_start) begin
            latched <= count;
        end
    end

endmodule

// File: rtl/line_driver.sv
module line_driver
    import seg_scan_pkg::*;
#(
    parameter int PHASE_W    = 17,
    parameter int GAP_CYCLES = 1
) (
    input  scan_pos_t              pos,
    input  bcd_pair_t              latched,
    input  logic [PHASE_W-1:0]     phase,
    output logic [NUM_LINES-1:0]   line_out,
    output logic [NUM_LINES-1:0]   line_oe
);

    localparam logic [PHASE_W-1:0] GAP_L = PHASE_W'(GAP_CYCLES);

    seg_pat_t             pattern;
    logic [NUM_LINES-1:0] sel;
    logic                 lit;
    logic                 in_gap;
    logic                 level;

    assign pattern = seg_decode((pos.digit == DIG_TENS) ? latched.tens : latched.units);
    assign in_gap  = (phase < GAP_L);
    assign level   = (pos.digit == DIG_TENS);

    always_comb begin
        for (int i = 0; i < NUM_LINES; i++) begin
            sel[i] = (pos.line == line_idx_t'(i));
        end
    end

    assign lit = |(pattern & sel);

    generate
        for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
            assign line_oe[g]  = sel[g] && lit && !in_gap;
            assign line_out[g] = level;
        end
    endgenerate

endmodule

// File: rtl/seg_scan_top.sv
module seg_scan_top
    import seg_scan_pkg::*;
#(
    parameter  int CLK_PER_SLOT  = 125000,
    parameter  int SLOTS_PER_SEC = 1000,
    parameter  int GAP_CYCLES    = 1,
    localparam int PHASE_W       = $clog2(CLK_PER_SLOT)
) (
    input  logic       clk,
    input  logic       rst,
    output logic [6:0] line_out,
    output logic [6:0] line_oe
);

    logic               slot_end;
    logic [PHASE_W-1:0] phase;
    bcd_pair_t          count;
    bcd_pair_t          latched;
    scan_pos_t          pos;
    logic               frame_start;

    scan_prescaler #(.CLK_PER_SLOT(CLK_PER_SLOT)) prescaler_i (
        .clk      (clk),
        .rst      (rst),
        .slot_end (slot_end),
        .phase    (phase)
    );

    sec_counter #(.SLOTS_PER_SEC(SLOTS_PER_SEC)) seconds_i (
        .clk       (clk),
        .rst       (rst),
        .slot_tick (slot_end),
        .count     (count)
    );

    scan_sequencer sequencer_i (
        .clk         (clk),
        .rst         (rst),
        .slot_end    (slot_end),
        .count       (count),
        .pos         (pos),
        .latched     (latched),
        .frame_start (frame_start)
    );

    line_driver #(.PHASE_W(PHASE_W), .GAP_CYCLES(GAP_CYCLES)) driver_i (
        .pos      (pos),
        .latched  (latched),
        .phase    (phase),
        .line_out (line_out),
        .line_oe  (line_oe)
    );

endmodule

// File: rtl/seg_scan_chk.sv
module seg_scan_chk
    import seg_scan_pkg::*;
#(
    parameter int GAP_CYCLES = 1
) (
    input logic       clk,
    input logic       rst,
    input logic [6:0] line_out,
    input logic [6:0] line_oe,
    input scan_pos_t  pos,
    input logic       slot_end,
    input logic       frame_start,
    input bcd_pair_t  count,
    input bcd_pair_t  latched
);

    AST_ONE_DRIVER: assert property (@(posedge clk) disable iff (rst)
        $onehot0(line_oe)); // R1

    AST_TENS_HIGH: assert property (@(posedge clk) disable iff (rst)
        (line_oe != 7'd0 && pos.digit == DIG_TENS) |-> ((line_out & line_oe) == line_oe)); // R2

    AST_UNITS_LOW: assert property (@(posedge clk) disable iff (rst)
        (line_oe != 7'd0 && pos.digit == DIG_UNITS) |-> ((line_out & line_oe) == 7'd0)); // R2

    AST_LINE_MATCH: assert property (@(posedge clk) disable iff (rst)
        (line_oe != 7'd0) |-> (line_oe == (7'd1 << pos.line))); // R3

    AST_GAP_AFTER_SLOT: assert property (@(posedge clk) disable iff (rst)
        (slot_end && GAP_CYCLES > 0) |=> (line_oe == 7'd0)); // R4

    AST_BCD_RANGE: assert property (@(posedge clk) disable iff (rst)
        (count.tens <= 4'd9) && (count.units <= 4'd9)); // R7

    AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (rst)
        ($past(count) == 8'h99 && count != $past(count)) |-> (count == 8'h00)); // R7

    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (rst)
        !frame_start |=> $stable(latched)); // R8

    AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pos == '0 && count == '0 && line_oe == 7'd0)); // R9

endmodule

bind seg_scan_top seg_scan_chk #(.GAP_CYCLES(GAP_CYCLES)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .line_out    (line_out),
    .line_oe     (line_oe),
    .pos         (pos),
    .slot_end    (slot_end),
    .frame_start (frame_start),
    .count       (count),
    .latched     (latched)
);

// File: tb/seg_scan_top_tb_top.sv
`timescale 1ns/1ps
module seg_scan_top_tb_top;

    localparam int CPS   = 8;
    localparam int SPS   = 20;
    localparam int GAP   = 1;
    localparam int FRAME = 14 * CPS;
    localparam int NCHK  = 12;

    localparam logic [6:0] SEG_REF [10] = '{7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66,
                                            7'h6D, 7'h7D, 7'h07, 7'h7F, 7'h6F};
    localparam int CHK_FRAME [NCHK] = '{0, 1, 2, 3, 10, 21, 70, 71, 142, 143, 144, 150};

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [6:0] line_out;
    logic [6:0] line_oe;

    int vectors = 0;
    int misses  = 0;
    int t       = 0;
    int cyc     = 0;
    bit done    = 0;

    seg_scan_top #(.CLK_PER_SLOT(CPS), .SLOTS_PER_SEC(SPS), .GAP_CYCLES(GAP)) dut_i (
        .clk      (clk),
        .rst      (rst),
        .line_out (line_out),
        .line_oe  (line_oe)
    );

    always #4 clk = ~clk;

    always @(posedge clk) begin
        if (rst) t <= 0;
        else     t <= t + 1;
        cyc <= cyc + 1;
        if (cyc > 100000 && !done) begin
            done = 1;
            misses++;
            $display("FAIL watchdog: actual cyc=%0d expected <=100000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    function automatic string tag_of(input int i);
        case (i)
            0:       return "R9";
            1:       return "R6";
            2:       return "R3";
            3:       return "R5";
            4:       return "R2";
            5:       return "R8";
            6, 7:    return "R4";
            default: return "R7";
        endcase
    endfunction

    task automatic expect_at(input int tt, output logic [6:0] eoe, output logic tens);
        int s, ph, f, p, ln, lat, val;
        s    = tt / CPS;
        ph   = tt % CPS;
        f    = s / 14;
        p    = s % 14;
        ln   = p % 7;
        tens = (p < 7);
        lat  = (f == 0) ? 0 : ((14 * f - 1) / SPS) % 100;
        val  = tens ? lat / 10 : lat % 10;
        eoe  = (ph >= GAP && SEG_REF[val][ln]) ? (7'd1 << ln) : 7'd0;
    endtask

    task automatic check_cycle(input string tag);
        logic [6:0] eoe;
        logic       tens;
        logic [6:0] eout_m;
        expect_at(t, eoe, tens);
        eout_m = tens ? eoe : 7'd0;
        vectors++;
        if (line_oe !== eoe || (line_out & line_oe) !== eout_m || $countones(line_oe) > 1) begin
            misses++;
            $display("FAIL %s/R1 t=%0d: actual oe=%b out&oe=%b expected oe=%b out&oe=%b",
                     tag, t, line_oe, line_out & line_oe, eoe, eout_m);
        end
    endtask

    task automatic check_frame(input int f, input string tag);
        while (t < f * FRAME) @(negedge clk);
        for (int c = 0; c < FRAME; c++) begin
            check_cycle(tag);
            @(negedge clk);
        end
    endtask

    task automatic check_reset(input string tag);
        vectors++;
        if (line_oe !== 7'd0 || t != 0) begin
            misses++;
            $display("FAIL %s reset: actual oe=%b t=%0d expected oe=0000000 t=0", tag, line_oe, t);
        end
    endtask

    initial begin
        @(negedge clk);
        @(negedge clk);
        check_reset("R9");
        rst = 1'b0;
        @(negedge clk);

        for (int i = 0; i < NCHK; i++) begin
            check_frame(CHK_FRAME[i], tag_of(i));
        end

        // R9: reset in the middle of a run; count and scan restart from 00, tens line 0
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check_reset("R9");
        rst = 1'b0;
        @(negedge clk);
        check_frame(0, "R9");
        check_frame(1, "R9");
        check_frame(2, "R7");

        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

endmodule